// File: doc/BRIEF.md
# Looping Playback Address Engine

This block produces the memory fetch address for audio playback out of a circular buffer that software defines. Software programs a buffer start address, a buffer end address and an alert address through a small register port. Setting the run bit loads the play pointer from the start address. From then on, every chunk-advance strobe from the sample path moves the pointer forward by one 16-byte chunk. When the pointer reaches the end of the buffer it folds back to the start, so playback loops until software clears the run bit.

Alongside the pointer, the block keeps a remaining-distance count. This count tells how many bytes of playback are left before the alert address is reached. It drops by one chunk per advance, and the alert interrupt fires on the advance that brings it to zero. The count is not reloaded when the buffer loops, so it runs on into large unsigned values. For a repeated alert, software rebases the count by moving the alert address forward by one buffer length.

Six sticky interrupt flags are kept. Four of them record mute and unmute events from the sample path, one records a playback stop and one records the position alert. A single interrupt line is driven from the flags that are enabled.

Top module: `pb_addr_engine`

## Requirements
- R1: After reset, all registers read zero, `fetch_valid_o` is 0 and `irq_o` is 0.
- R2: The register port has eight word registers, selected by index: 0 control (bit0 = run), 1 buffer start, 2 buffer end, 3 alert address, 4 remaining count (read-only), 5 play pointer (read-only), 6 flags (write one to clear), 7 interrupt enable (bits 5:0). The address registers 1 to 3 keep only bits 27:3 (mask 0x0FFFFFF8), and their other bits read zero.
- R3: While the run bit is set, writes to the buffer start and buffer end registers are ignored.
- R4: Writing 1 to the run bit while it is 0 loads the pointer with the buffer start address. While the run bit is set, `fetch_addr_o` equals the pointer and each `chunk_adv_i` cycle adds 16 to it. If the sum is greater than or equal to the end address, the pointer loads the start address instead. While the run bit is 0, `chunk_adv_i` has no effect.
- R5: On start, the remaining count is loaded with (alert − start) when alert ≥ start. Otherwise it is loaded with (alert − start + end − start). Each advance subtracts 16, modulo 2^28. The count is never reloaded when the pointer wraps.
- R6: A write to the alert register while running adds (new alert − old alert) to the remaining count.
- R7: Flag bit3 (position alert) is set by the advance that makes the remaining count zero, and by no other advance.
- R8: The flag bits are bit0 mute A, bit1 mute B, bit4 unmute A and bit5 unmute B. These are set by one-cycle pulses on `mute_evt_i[0]`, `mute_evt_i[1]`, `unmute_evt_i[0]` and `unmute_evt_i[1]`. Every flag stays set until a 1 is written to its bit in register 6. If a set and a clear happen in the same cycle, the set wins.
- R9: Writing 0 to the run bit while running stops playback. `fetch_valid_o` drops and flag bit2 (stop) is set.
- R10: `irq_o` is 1 exactly when some flag bit and the same enable bit in register 7 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 3 | Write register index |
| reg_wdata_i | input | 32 | Write data |
| reg_raddr_i | input | 3 | Read register index |
| reg_rdata_o | output | 32 | Read data (combinational) |
| chunk_adv_i | input | 1 | One chunk consumed by the sample path |
| mute_evt_i | input | 2 | Mute event pulses A, B |
| unmute_evt_i | input | 2 | Unmute event pulses A, B |
| fetch_addr_o | output | 28 | Current fetch address |
| fetch_valid_o | output | 1 | Playback running |
| irq_o | output | 1 | Interrupt request |

## Verification
The main test sweeps buffer lengths of one to four chunks against every alert offset inside each buffer. Running past two full loops separates a correct fold-back point from an off-by-one, and shows that the remaining count goes on below zero rather than reloading. An alert address placed below the start checks the wrapped distance formula. A rebase write after a first alert shows that a second alert comes exactly one buffer length later. Event pulses, set-and-clear collisions and partial enable masks tell apart the flag holding, the clearing and the interrupt gating.

// File: rtl/pb_pkg.sv
package pb_pkg;
  typedef enum logic [2:0] {
    RG_CTRL   = 3'd0,
    RG_START  = 3'd1,
    RG_END    = 3'd2,
    RG_ALERT  = 3'd3,
    RG_REMAIN = 3'd4,
    RG_PTR    = 3'd5,
    RG_FLAGS  = 3'd6,
    RG_IRQEN  = 3'd7
  } pb_reg_e;

  localparam int NFLAGS     = 6;
  localparam int FL_MUTE_A  = 0;
  localparam int FL_MUTE_B  = 1;
  localparam int FL_STOP    = 2;
  localparam int FL_ALERT   = 3;
  localparam int FL_UNMUTE_A = 4;
  localparam int FL_UNMUTE_B = 5;
endpackage

// File: rtl/pb_ptr_unit.sv
module pb_ptr_unit #(
  parameter int ADDR_W     = 28,
  parameter int CHUNK_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              run_i,
  input  logic              adv_i,
  input  logic              rebase_i,
  input  logic [ADDR_W-1:0] buf_lo_i,
  input  logic [ADDR_W-1:0] buf_hi_i,
  input  logic [ADDR_W-1:0] alert_old_i,
  input  logic [ADDR_W-1:0] alert_new_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [ADDR_W-1:0] remain_o,
  output logic              alert_evt_o
);
  localparam logic [ADDR_W-1:0] CHUNK = ADDR_W'(1) << CHUNK_LOG2;

  // distance from buffer start to alert point, folding once through the buffer
  function automatic logic [ADDR_W-1:0] lead_dist(
    input logic [ADDR_W-1:0] lo, input logic [ADDR_W-1:0] hi,
    input logic [ADDR_W-1:0] tgt);
    if (tgt >= lo) return tgt - lo;
    return tgt - lo + (hi - lo);
  endfunction

  function automatic logic [ADDR_W-1:0] step_ptr(
    input logic [ADDR_W-1:0] p, input logic [ADDR_W-1:0] lo,
    input logic [ADDR_W-1:0] hi);
    logic [ADDR_W-1:0] n;
    n = p + CHUNK;
    return (n >= hi) ? lo : n;
  endfunction

  logic [ADDR_W-1:0] ptr_q, remain_q, rem_adj, rem_nxt;
  logic              step;

  always_comb begin
    step    = run_i && adv_i;
    rem_adj = remain_q + ((rebase_i && run_i) ? (alert_new_i - alert_old_i) : '0);
    rem_nxt = step ? (rem_adj - CHUNK) : rem_adj;
  end

  assign alert_evt_o = step && (rem_nxt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      remain_q <= '0;
    end else if (load_i) begin
      ptr_q    <= buf_lo_i;
      remain_q <= lead_dist(buf_lo_i, buf_hi_i, alert_old_i);
    end else if (run_i) begin
      if (step) ptr_q <= step_ptr(ptr_q, buf_lo_i, buf_hi_i);
      remain_q <= rem_nxt;
    end
  end

  assign ptr_o    = ptr_q;
  assign remain_o = remain_q;

  assert_ptr_in_buf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !load_i && (buf_lo_i < buf_hi_i)) |-> (ptr_q >= buf_lo_i && ptr_q < buf_hi_i));
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !load_i) |=> $stable(ptr_q));
  assert_remain_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && adv_i && !rebase_i && !load_i) |=> (remain_q == $past(remain_q) - CHUNK));
  assert_alert_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alert_evt_o |=> (remain_q == '0));
endmodule

// File: rtl/pb_irq_unit.sv
module pb_irq_unit #(
  parameter int NF = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_i,
  input  logic          clr_en_i,
  input  logic [NF-1:0] clr_i,
  input  logic [NF-1:0] en_i,
  output logic [NF-1:0] flags_o,
  output logic          irq_o
);
  logic [NF-1:0] flag_q;

  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)                    flag_q[i] <= 1'b0;
      else if (set_i[i])             flag_q[i] <= 1'b1;
      else if (clr_en_i && clr_i[i]) flag_q[i] <= 1'b0;
    end

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !(clr_en_i && clr_i[i])) |=> flag_q[i]);
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flag_q[i]);
  end

  assign flags_o = flag_q;
  assign irq_o   = |(flag_q & en_i);
endmodule

// File: rtl/pb_addr_engine.sv
module pb_addr_engine #(
  parameter int ADDR_W     = 28,
  parameter int GRAN_LSB   = 3,
  parameter int CHUNK_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic [2:0]        reg_waddr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic [2:0]        reg_raddr_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              chunk_adv_i,
  input  logic [1:0]        mute_evt_i,
  input  logic [1:0]        unmute_evt_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              fetch_valid_o,
  output logic              irq_o
);
  import pb_pkg::*;

  localparam logic [ADDR_W-1:0] ADDR_MASK = ~(ADDR_W'((1 << GRAN_LSB) - 1));

  logic              run_q;
  logic [ADDR_W-1:0] start_q, end_q, alert_q, wr_addr_val;
  logic [NFLAGS-1:0] irqen_q, flags, set_vec;
  logic [ADDR_W-1:0] ptr, remain;
  logic              wr_ctrl, wr_start, wr_end, wr_alert, wr_flags, wr_irqen;
  logic              start_pls, stop_pls, alert_evt;

  assign wr_addr_val = reg_wdata_i[ADDR_W-1:0] & ADDR_MASK;
  assign wr_ctrl   = reg_wr_i && (reg_waddr_i == RG_CTRL);
  assign wr_start  = reg_wr_i && (reg_waddr_i == RG_START);
  assign wr_end    = reg_wr_i && (reg_waddr_i == RG_END);
  assign wr_alert  = reg_wr_i && (reg_waddr_i == RG_ALERT);
  assign wr_flags  = reg_wr_i && (reg_waddr_i == RG_FLAGS);
  assign wr_irqen  = reg_wr_i && (reg_waddr_i == RG_IRQEN);
  assign start_pls = wr_ctrl && reg_wdata_i[0] && !run_q;
  assign stop_pls  = wr_ctrl && !reg_wdata_i[0] && run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      start_q <= '0;
      end_q   <= '0;
      alert_q <= '0;
      irqen_q <= '0;
    end else begin
      if (wr_ctrl)            run_q   <= reg_wdata_i[0];
      if (wr_start && !run_q) start_q <= wr_addr_val;
      if (wr_end && !run_q)   end_q   <= wr_addr_val;
      if (wr_alert)           alert_q <= wr_addr_val;
      if (wr_irqen)           irqen_q <= reg_wdata_i[NFLAGS-1:0];
    end
  end

  pb_ptr_unit #(.ADDR_W(ADDR_W), .CHUNK_LOG2(CHUNK_LOG2)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load_i(start_pls), .run_i(run_q),
    .adv_i(chunk_adv_i), .rebase_i(wr_alert),
    .buf_lo_i(start_q), .buf_hi_i(end_q),
    .alert_old_i(alert_q), .alert_new_i(wr_addr_val),
    .ptr_o(ptr), .remain_o(remain), .alert_evt_o(alert_evt)
  );

  always_comb begin
    set_vec              = '0;
    set_vec[FL_MUTE_A]   = mute_evt_i[0];
    set_vec[FL_MUTE_B]   = mute_evt_i[1];
    set_vec[FL_STOP]     = stop_pls;
    set_vec[FL_ALERT]    = alert_evt;
    set_vec[FL_UNMUTE_A] = unmute_evt_i[0];
    set_vec[FL_UNMUTE_B] = unmute_evt_i[1];
  end

  pb_irq_unit #(.NF(NFLAGS)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_en_i(wr_flags),
    .clr_i(reg_wdata_i[NFLAGS-1:0]), .en_i(irqen_q),
    .flags_o(flags), .irq_o(irq_o)
  );

  always_comb begin
    case (reg_raddr_i)
      RG_CTRL:   reg_rdata_o = 32'(run_q);
      RG_START:  reg_rdata_o = 32'(start_q);
      RG_END:    reg_rdata_o = 32'(end_q);
      RG_ALERT:  reg_rdata_o = 32'(alert_q);
      RG_REMAIN: reg_rdata_o = 32'(remain);
      RG_PTR:    reg_rdata_o = 32'(ptr);
      RG_FLAGS:  reg_rdata_o = 32'(flags);
      default:   reg_rdata_o = 32'(irqen_q);
    endcase
  end

  assign fetch_addr_o  = ptr;
  assign fetch_valid_o = run_q;

  assert_addr_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> ($stable(start_q) && $stable(end_q)));
  assert_stop_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> flags[FL_STOP]);
  assert_addr_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((start_q & ~ADDR_MASK) == '0) && ((alert_q & ~ADDR_MASK) == '0));
endmodule

// File: tb/pb_addr_engine_tb.sv
module pb_addr_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic [2:0]  raddr = '0;
  logic [31:0] rdata;
  logic        adv = 1'b0;
  logic [1:0]  mute = '0;
  logic [1:0]  unmute = '0;
  logic [27:0] fetch_addr;
  logic        fetch_valid;
  logic        irq;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pb_addr_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_waddr_i(waddr),
    .reg_wdata_i(wdata), .reg_raddr_i(raddr), .reg_rdata_o(rdata),
    .chunk_adv_i(adv), .mute_evt_i(mute), .unmute_evt_i(unmute),
    .fetch_addr_o(fetch_addr), .fetch_valid_o(fetch_valid), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; waddr = a; wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    raddr = a;
    #1;
    d = rdata;
  endtask

  task automatic step_adv();
    @(negedge clk); adv = 1'b1;
    @(negedge clk); adv = 1'b0;
  endtask

  task automatic chk_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] base, v;
    logic [27:0] rem_e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int r = 0; r < 8; r++) chk_reg("R1", 3'(r), 32'h0);
    chk("R1", {31'b0, fetch_valid}, 32'h0);
    chk("R1", {31'b0, irq}, 32'h0);

    // R2 masking of address registers
    wr(3'd1, 32'hFFFF_FFFF); chk_reg("R2", 3'd1, 32'h0FFF_FFF8);
    wr(3'd3, 32'h1234_567F); chk_reg("R2", 3'd3, 32'h0234_5678);
    wr(3'd2, 32'h0000_0107); chk_reg("R2", 3'd2, 32'h0000_0100);

    // R4 advance while idle has no effect
    wr(3'd1, 32'h100); wr(3'd2, 32'h140); wr(3'd3, 32'h120);
    wr(3'd0, 1); wr(3'd0, 0); wr(3'd6, 32'h3F);
    step_adv(); step_adv();
    chk_reg("R4 idle", 3'd5, 32'h100);
    chk_reg("R5 idle", 3'd4, 32'h20);

    // Sweep buffer length n and alert offset a
    for (int n = 1; n <= 4; n++) begin
      for (int a = 1; a <= n; a++) begin
        base = 32'h2000 + 32'(n) * 32'h400 + 32'(a) * 32'h40;
        wr(3'd1, base); wr(3'd2, base + 32'(n) * 16); wr(3'd3, base + 32'(a) * 16);
        wr(3'd7, 32'h3F); wr(3'd6, 32'h3F);
        wr(3'd0, 1);
        chk_reg("R4 start", 3'd5, base);
        chk("R4 fetch", {4'b0, fetch_addr}, base);
        chk("R4 valid", {31'b0, fetch_valid}, 32'h1);
        chk_reg("R5 load", 3'd4, 32'(a) * 16);
        for (int k = 1; k <= 2 * n + 1; k++) begin
          step_adv();
          chk_reg("R4 wrap", 3'd5, base + 32'(k % n) * 16);
          rem_e = 28'(32'(a) * 16 - 32'(k) * 16);
          chk_reg("R5 count", 3'd4, {4'b0, rem_e});
          rd(3'd6, v);
          chk("R7 alert", {31'b0, v[3]}, {31'b0, k == a});
          chk("R10 irq", {31'b0, irq}, {31'b0, k == a});
          if (k == a) begin
            wr(3'd6, 32'h8);
            chk_reg("R8 ack", 3'd6, 32'h0);
          end
        end
        // R3 writes ignored while running
        wr(3'd1, 32'h0FF0); wr(3'd2, 32'h0FF0);
        chk_reg("R3 start", 3'd1, base);
        chk_reg("R3 end", 3'd2, base + 32'(n) * 16);
        wr(3'd0, 0);
        chk_reg("R9 stop", 3'd6, 32'h4);
        chk("R9 valid", {31'b0, fetch_valid}, 32'h0);
        wr(3'd6, 32'h4);
      end
    end

    // R5 alert below start: distance folds through buffer
    wr(3'd1, 32'h100); wr(3'd2, 32'h140); wr(3'd3, 32'h0F0);
    wr(3'd0, 1);
    chk_reg("R5 fold", 3'd4, 32'h30);
    wr(3'd0, 0); wr(3'd6, 32'h3F);

    // R6 rebase after first alert gives second alert one buffer later
    wr(3'd3, 32'h120); wr(3'd0, 1);
    step_adv(); step_adv();
    chk_reg("R7 first", 3'd6, 32'h8);
    wr(3'd6, 32'h8);
    wr(3'd3, 32'h160);
    chk_reg("R6 rebase", 3'd4, 32'h40);
    for (int k = 1; k <= 4; k++) begin
      step_adv();
      rd(3'd6, v);
      chk("R6 second", {31'b0, v[3]}, {31'b0, k == 4});
    end
    wr(3'd0, 0); wr(3'd6, 32'h3F);

    // R8 event pulses map to bits 0,1,4,5
    @(negedge clk); mute = 2'b01; @(negedge clk); mute = 2'b00;
    chk_reg("R8 muteA", 3'd6, 32'h01);
    @(negedge clk); unmute = 2'b10; @(negedge clk); unmute = 2'b00;
    chk_reg("R8 unmuteB", 3'd6, 32'h21);
    @(negedge clk); mute = 2'b10; unmute = 2'b01; @(negedge clk); mute = 2'b00; unmute = 2'b00;
    chk_reg("R8 both", 3'd6, 32'h33);
    wr(3'd6, 32'h01);
    chk_reg("R8 w1c", 3'd6, 32'h32);
    // set and clear collide: set wins
    @(negedge clk);
    reg_wr = 1'b1; waddr = 3'd6; wdata = 32'h02; mute = 2'b10;
    @(negedge clk);
    reg_wr = 1'b0; mute = 2'b00;
    chk_reg("R8 setwins", 3'd6, 32'h32);

    // R10 enable masking
    wr(3'd6, 32'h30);
    wr(3'd7, 32'h01);
    chk("R10 masked", {31'b0, irq}, 32'h0);
    wr(3'd7, 32'h02);
    chk("R10 enabled", {31'b0, irq}, 32'h1);
    wr(3'd6, 32'h02);
    chk("R10 cleared", {31'b0, irq}, 32'h0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule